// File: doc/BRIEF.md
# Two-Level Banked Interrupt Controller

This block gathers interrupt requests from up to four banks of 32 sources and presents one winning source number to the processor on a normal interrupt line. A separate fast-interrupt line has its own winner. Every source has a configuration word that holds three things: the route (normal or fast), the trigger type (edge or level) and a 5-bit priority. Bank 0 is the first level. Banks 1 and above form the second level, which feeds into one input of bank 0 (parameter `CASC_BIT`). Second-level sources therefore reach the processor only when that bank 0 input is unmasked.

Software uses a small word-addressed register port. The address is `{bank, word}`, where word is 6 bits:

| Word | Register |
|------|----------|
| 0 | raw request |
| 1 | mask |
| 2 | acknowledge |
| 32 + n | configuration word of source n |

Each arbiter (first-level normal, first-level fast, second-level) is a two-state machine:

- **ARB_IDLE**: takes the *grant* transition to ARB_HOLD, latching the winner, when any eligible request exists.
- **ARB_HOLD**: keeps the winner until an acknowledge write takes the *release* transition back to ARB_IDLE. Arbitration then runs again.

Top module: `intc_top`

## Requirements
- R1: After reset every mask bit reads 1, every configuration word reads 0, and `irq_out` and `fiq_out` are 0.
- R2: A source number is bank × 32 + bit, so bank = number >> 5 and bit = number & 31. `irq_src` and `fiq_src` report this number.
- R3: A mask bit of 1 blocks its source from arbitration. A mask bit of 0 admits it.
- R4: A configuration word stores bit 0 = fast route, bit 1 = trigger (1 edge, 0 level) and bits 6:2 = priority. It reads back in the same layout with the upper bits 0.
- R5: The fast-route bit is stored as 0 in every bank except bank 0.
- R6: Priority value 0 is the most urgent. Among equal priorities the lowest source number wins.
- R7: An edge source latches a rising input in its raw bit. A level source's raw bit follows its input.
- R8: Writing the raw register clears each edge latch whose data bit is 0. Acknowledging a held edge source clears its latch.
- R9: A granted winner keeps its line, number and priority until the matching acknowledge write, even if a more urgent source arrives. After the acknowledge, arbitration runs again.
- R10: An acknowledge write to bank 0 with data bit 0 set releases the first-level normal winner, and with data bit 1 set releases the fast winner. A write to a higher bank with bit 0 set releases the second-level winner.
- R11: Second-level sources drive bank 0 input `CASC_BIT`. The external input at that position is ignored. While bank 0 holds that input, `irq_src` and `irq_prio` report the second-level winner. Releasing the cascade takes a second-level acknowledge followed by a bank 0 acknowledge.
- R12: Bank 0 sources routed fast are arbitrated separately and appear on `fiq_out`, `fiq_src` and `fiq_prio`, never on `irq_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_BANKS*32 | Request inputs, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | BANK_W+6 | Write address {bank, word} |
| wdata | input | 32 | Write data |
| rd_addr | input | BANK_W+6 | Read address {bank, word} |
| rd_data | output | 32 | Read data, combinational |
| irq_out | output | 1 | Normal interrupt line |
| irq_src | output | BANK_W+5 | Held normal source number |
| irq_prio | output | 5 | Held normal priority |
| fiq_out | output | 1 | Fast interrupt line |
| fiq_src | output | BANK_W+5 | Held fast source number |
| fiq_prio | output | 5 | Held fast priority |

## Verification
The bench aims at ties in priority. A design that picked the highest index, or compared with less-or-equal, would report the wrong source. It also raises a more urgent request while a winner is held; a design that re-arbitrates freely would switch sources before any acknowledge. Cascade paths are run with the bank 0 input both masked and unmasked, and with a fast-route bit written into bank 1. A leaky design would then raise the line through a masked cascade, or send a second-level source to the fast line. Edge latches are cleared by raw writes and by acknowledges; a design missing either clear would re-raise a serviced source.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic {ARB_IDLE, ARB_HOLD} arb_state_e;

    // configuration word layout: [6:2] priority, [1] edge trigger, [0] fast route
    typedef struct packed {
        logic [4:0] prio;
        logic       edge_trig;
        logic       to_fiq;
    } src_cfg_t;

    localparam logic [5:0] WORD_RAW  = 6'd0;
    localparam logic [5:0] WORD_MASK = 6'd1;
    localparam logic [5:0] WORD_ACK  = 6'd2;
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int N  = 32,
    parameter int PW = 5,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic [N*PW-1:0] prio_flat,
    input  logic          ack,
    output logic          valid,
    output logic [IW-1:0] idx,
    output logic [PW-1:0] prio
);
    arb_state_e st, st_nx;
    logic          found;
    logic [IW-1:0] cand_i;
    logic [PW-1:0] cand_p;

    // strict compare keeps the lowest index on equal priority
    always_comb begin
        found  = 1'b0;
        cand_i = '0;
        cand_p = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || prio_flat[i*PW +: PW] < cand_p)) begin
                found  = 1'b1;
                cand_i = IW'(i);
                cand_p = prio_flat[i*PW +: PW];
            end
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ARB_IDLE: if (found) st_nx = ARB_HOLD;
            ARB_HOLD: if (ack)   st_nx = ARB_IDLE;
            default:             st_nx = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ARB_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            prio <= '0;
        end else if (st == ARB_IDLE && found) begin
            idx  <= cand_i;
            prio <= cand_p;
        end
    end

    assign valid = (st == ARB_HOLD);
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int BANK_ID = 0,
    localparam int NS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] src_in,
    input  logic          wr_en,
    input  logic [5:0]    wr_word,
    input  logic [31:0]   wdata,
    input  logic [NS-1:0] ack_clr,
    input  logic [5:0]    rd_word,
    output logic [NS-1:0] raw,
    output logic [NS-1:0] mask,
    output logic [NS-1:0] to_fiq,
    output logic [NS*5-1:0] prio_flat,
    output logic [31:0]   rd_data
);
    src_cfg_t      cfg [NS];
    logic [NS-1:0] src_q, latch, is_edge;
    logic          raw_wr;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            is_edge[i]          = cfg[i].edge_trig;
            to_fiq[i]           = cfg[i].to_fiq;
            prio_flat[i*5 +: 5] = cfg[i].prio;
        end
    end

    assign raw    = (is_edge & latch) | (~is_edge & src_in);
    assign raw_wr = wr_en && (wr_word == WORD_RAW);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            latch <= '0;
            mask  <= '1;
            for (int i = 0; i < NS; i++) cfg[i] <= '0;
        end else begin
            src_q <= src_in;
            latch <= (latch & ~ack_clr & (raw_wr ? wdata : 32'hFFFF_FFFF))
                   | (src_in & ~src_q & is_edge);
            if (wr_en && wr_word == WORD_MASK) mask <= wdata;
            if (wr_en && wr_word[5])
                cfg[wr_word[4:0]] <= '{prio: wdata[6:2], edge_trig: wdata[1],
                                       to_fiq: (BANK_ID == 0) ? wdata[0] : 1'b0};
        end
    end

    always_comb begin
        if (rd_word[5]) rd_data = {25'b0, cfg[rd_word[4:0]]};
        else if (rd_word == WORD_RAW)  rd_data = raw;
        else if (rd_word == WORD_MASK) rd_data = mask;
        else rd_data = '0;
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int CASC_BIT  = 0,
    localparam int NSRC   = NUM_BANKS * 32,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int SRC_W  = BANK_W + 5,
    localparam int ADDR_W = BANK_W + 6,
    localparam int N2     = (NUM_BANKS > 1) ? (NUM_BANKS - 1) * 32 : 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq_out,
    output logic [SRC_W-1:0]  irq_src,
    output logic [4:0]        irq_prio,
    output logic              fiq_out,
    output logic [SRC_W-1:0]  fiq_src,
    output logic [4:0]        fiq_prio
);
    logic [31:0]  raw_b  [NUM_BANKS];
    logic [31:0]  mask_b [NUM_BANKS];
    logic [31:0]  fiq_b  [NUM_BANKS];
    logic [159:0] prio_b [NUM_BANKS];
    logic [31:0]  clr_b  [NUM_BANKS];
    logic [31:0]  rdd_b  [NUM_BANKS];
    logic [31:0]  bsrc_b [NUM_BANKS];

    logic [BANK_W-1:0] wr_bank, rd_bank;
    logic [5:0]        wr_word;
    logic              ack_wr, ack_l1i, ack_l1f, ack_l2;
    logic              l1i_valid, l1f_valid, l2_valid, cascaded;
    logic [4:0]        l1i_idx, l1f_idx, l1i_prio, l1f_prio, l2_prio;
    logic [SRC_W-1:0]  l2_num;
    logic [31:0]       l1_pend;

    assign wr_bank = wr_addr[ADDR_W-1:6];
    assign wr_word = wr_addr[5:0];
    assign rd_bank = rd_addr[ADDR_W-1:6];
    assign ack_wr  = wr_en && (wr_word == WORD_ACK);
    assign ack_l1i = ack_wr && (wr_bank == '0) && wdata[0];
    assign ack_l1f = ack_wr && (wr_bank == '0) && wdata[1];
    assign ack_l2  = ack_wr && (wr_bank != '0) && wdata[0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        if (b == 0 && NUM_BANKS > 1) begin : g_casc
            assign bsrc_b[b] = (src_in[31:0] & ~(32'h1 << CASC_BIT))
                             | ({31'b0, l2_valid} << CASC_BIT);
        end else begin : g_plain
            assign bsrc_b[b] = src_in[b*32 +: 32];
        end
        if (b == 0) begin : g_clr0
            assign clr_b[b] = ((ack_l1i && l1i_valid) ? (32'h1 << l1i_idx) : 32'h0)
                            | ((ack_l1f && l1f_valid) ? (32'h1 << l1f_idx) : 32'h0);
        end else begin : g_clrn
            assign clr_b[b] = (ack_l2 && l2_valid && l2_num[SRC_W-1:5] == BANK_W'(b))
                            ? (32'h1 << l2_num[4:0]) : 32'h0;
        end
        intc_bank #(.BANK_ID(b)) u_bank (
            .clk(clk), .rst_n(rst_n), .src_in(bsrc_b[b]),
            .wr_en(wr_en && wr_bank == BANK_W'(b)), .wr_word(wr_word), .wdata(wdata),
            .ack_clr(clr_b[b]), .rd_word(rd_addr[5:0]),
            .raw(raw_b[b]), .mask(mask_b[b]), .to_fiq(fiq_b[b]),
            .prio_flat(prio_b[b]), .rd_data(rdd_b[b])
        );
    end

    assign l1_pend = raw_b[0] & ~mask_b[0];

    intc_arbiter #(.N(32), .PW(5)) u_l1_irq (
        .clk(clk), .rst_n(rst_n), .req(l1_pend & ~fiq_b[0]), .prio_flat(prio_b[0]),
        .ack(ack_l1i), .valid(l1i_valid), .idx(l1i_idx), .prio(l1i_prio)
    );

    intc_arbiter #(.N(32), .PW(5)) u_l1_fiq (
        .clk(clk), .rst_n(rst_n), .req(l1_pend & fiq_b[0]), .prio_flat(prio_b[0]),
        .ack(ack_l1f), .valid(l1f_valid), .idx(l1f_idx), .prio(l1f_prio)
    );

    if (NUM_BANKS > 1) begin : g_l2
        localparam int IW2 = $clog2(N2);
        logic [N2-1:0]   l2_req;
        logic [N2*5-1:0] l2_pf;
        logic [IW2-1:0]  l2_idx;
        always_comb begin
            for (int b = 1; b < NUM_BANKS; b++) begin
                l2_req[(b-1)*32 +: 32]  = raw_b[b] & ~mask_b[b] & ~fiq_b[b];
                l2_pf[(b-1)*160 +: 160] = prio_b[b];
            end
        end
        intc_arbiter #(.N(N2), .PW(5)) u_l2 (
            .clk(clk), .rst_n(rst_n), .req(l2_req), .prio_flat(l2_pf),
            .ack(ack_l2), .valid(l2_valid), .idx(l2_idx), .prio(l2_prio)
        );
        assign l2_num = SRC_W'(32) + SRC_W'(l2_idx);
    end else begin : g_nol2
        assign l2_valid = 1'b0;
        assign l2_prio  = '0;
        assign l2_num   = '0;
    end

    assign cascaded = (NUM_BANKS > 1) && (l1i_idx == 5'(CASC_BIT));
    assign irq_out  = l1i_valid;
    assign irq_src  = cascaded ? l2_num  : SRC_W'(l1i_idx);
    assign irq_prio = cascaded ? l2_prio : l1i_prio;
    assign fiq_out  = l1f_valid;
    assign fiq_src  = SRC_W'(l1f_idx);
    assign fiq_prio = l1f_prio;
    assign rd_data  = (int'(rd_bank) < NUM_BANKS) ? rdd_b[rd_bank] : 32'h0;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
    parameter int SRC_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             irq_out,
    input logic [SRC_W-1:0] irq_src,
    input logic [4:0]       irq_prio,
    input logic             fiq_out,
    input logic [SRC_W-1:0] fiq_src,
    input logic [4:0]       fiq_prio
);
    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !wr_en) |=> (irq_out && $stable(irq_src) && $stable(irq_prio)));

    // R12
    fiq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_out && !wr_en) |=> (fiq_out && $stable(fiq_src) && $stable(fiq_prio)));

    // R10
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |-> $past(wr_en));

    // R10
    fiq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fiq_out) |-> $past(wr_en));
endmodule

bind intc_top intc_chk #(.SRC_W(SRC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .irq_out(irq_out), .irq_src(irq_src), .irq_prio(irq_prio),
    .fiq_out(fiq_out), .fiq_src(fiq_src), .fiq_prio(fiq_prio)
);

// File: tb/tb_intc_top.sv
`timescale 1ns/1ps
module tb_intc_top;
    localparam int NB = 2, CASC = 0, BW = 1, AW = BW + 6, NS = NB * 32;

    logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [NS-1:0] src = '0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0]   wdata = '0, rd_data;
    logic          irq_out, fiq_out;
    logic [BW+4:0] irq_src, fiq_src;
    logic [4:0]    irq_prio, fiq_prio;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [31:0] m_mask [NB];
    int          m_prio [NB][32];
    logic        m_fiq  [NB][32];

    intc_top #(.NUM_BANKS(NB), .CASC_BIT(CASC)) dut (
        .clk(clk), .rst_n(rst_n), .src_in(src), .wr_en(wr_en), .wr_addr(wr_addr),
        .wdata(wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_out(irq_out), .irq_src(irq_src), .irq_prio(irq_prio),
        .fiq_out(fiq_out), .fiq_src(fiq_src), .fiq_prio(fiq_prio)
    );

    always #2.5 clk = ~clk;

    function automatic logic [AW-1:0] ad(int bank, int word);
        return {bank[BW-1:0], word[5:0]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int bank, int word, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ad(bank, word); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int bank, int word, output logic [31:0] d);
        rd_addr = ad(bank, word);
        #1 d = rd_data;
    endtask

    task automatic model(output logic iv, output int is, output int ip,
                         output logic fv, output int fs, output int fp);
        logic l2v = 1'b0; int l2i = 0, l2p = 31; logic cp;
        for (int b = 1; b < NB; b++)
            for (int i = 0; i < 32; i++)
                if (src[b*32+i] && !m_mask[b][i] && (!l2v || m_prio[b][i] < l2p)) begin
                    l2v = 1'b1; l2i = b*32 + i; l2p = m_prio[b][i];
                end
        cp = l2v && !m_mask[0][CASC];
        iv = 1'b0; is = 0; ip = 0; fv = 1'b0; fs = 0; fp = 0;
        if (cp && !m_fiq[0][CASC]) begin
            iv = 1'b1; is = l2i; ip = l2p;
        end else begin
            for (int i = 0; i < 32; i++)
                if (i != CASC && src[i] && !m_mask[0][i] && !m_fiq[0][i] && (!iv || m_prio[0][i] < ip)) begin
                    iv = 1'b1; is = i; ip = m_prio[0][i];
                end
        end
        if (cp && m_fiq[0][CASC]) begin
            fv = 1'b1; fs = CASC; fp = m_prio[0][CASC];
        end else begin
            for (int i = 0; i < 32; i++)
                if (i != CASC && src[i] && !m_mask[0][i] && m_fiq[0][i] && (!fv || m_prio[0][i] < fp)) begin
                    fv = 1'b1; fs = i; fp = m_prio[0][i];
                end
        end
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic iv, fv; int is, ip, fs, fp;
        void'($urandom(32'h5EED_0042));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        chk("R1 irq_out", irq_out, 0);
        chk("R1 fiq_out", fiq_out, 0);
        rd(0, 1, d); chk("R1 mask bank0", d, 32'hFFFF_FFFF);
        rd(1, 1, d); chk("R1 mask bank1", d, 32'hFFFF_FFFF);
        rd(0, 32 + 5, d); chk("R1 cfg word", d, 0);

        // R4 layout readback, R5 fast bit forced off outside bank 0
        wr(0, 32 + 3, 32'hFFFF_FF7F); rd(0, 32 + 3, d); chk("R4 cfg readback", d, 32'h7F);
        wr(1, 32 + 3, 32'h7F);        rd(1, 32 + 3, d); chk("R5 bank1 fast bit", d, 32'h7E);

        // R7 edge latch and level follow
        wr(0, 32 + 4, 32'h2);
        @(negedge clk) src[4] = 1'b1;
        @(negedge clk) src[4] = 1'b0;
        cyc(1); rd(0, 0, d); chk("R7 edge latched", d[4], 1);
        src[6] = 1'b1; cyc(1); rd(0, 0, d); chk("R7 level high", d[6], 1);
        src[6] = 1'b0; cyc(1); rd(0, 0, d); chk("R7 level low", d[6], 0);
        // R8 raw write with 0 clears latch
        wr(0, 0, 32'hFFFF_FFEF); rd(0, 0, d); chk("R8 raw clear", d[4], 0);

        // R3 unmask, R2 number, R8 acknowledge clears edge latch
        wr(0, 1, ~(32'h1 << 4));
        @(negedge clk) src[4] = 1'b1;
        @(negedge clk) src[4] = 1'b0;
        cyc(3);
        chk("R3 unmasked edge raises irq", irq_out, 1);
        chk("R2 irq_src", irq_src, 4);
        wr(0, 2, 32'h1); cyc(3);
        chk("R8 ack releases", irq_out, 0);
        rd(0, 0, d); chk("R8 ack clears latch", d[4], 0);

        // R9 hold until acknowledge
        wr(0, 32 + 10, 9 << 2); wr(0, 32 + 11, 2 << 2);
        wr(0, 1, ~(32'h3 << 10));
        src[10] = 1'b1; cyc(3);
        chk("R9 first winner", irq_src, 10);
        src[11] = 1'b1; cyc(3);
        chk("R9 held src", irq_src, 10);
        chk("R9 held prio", irq_prio, 9);
        wr(0, 2, 32'h1); cyc(3);
        chk("R9 rearbitrate src", irq_src, 11);
        chk("R9 rearbitrate prio", irq_prio, 2);
        src[10] = 1'b0; src[11] = 1'b0; wr(0, 2, 32'h1); cyc(3);
        chk("R9 idle", irq_out, 0);

        // R6 tie goes to lowest number
        wr(0, 32 + 20, 5 << 2); wr(0, 32 + 21, 5 << 2);
        wr(0, 1, ~(32'h3 << 20));
        src[21] = 1'b1; src[20] = 1'b1; cyc(3);
        chk("R6 tie", irq_src, 20);
        src[20] = 1'b0; src[21] = 1'b0; wr(0, 2, 32'h1); cyc(3);

        // R12 fast route, R10 per-line acknowledge
        wr(0, 32 + 7, 32'h0D); wr(0, 1, ~(32'h1 << 7));
        src[7] = 1'b1; cyc(3);
        chk("R12 fiq_out", fiq_out, 1);
        chk("R12 fiq_src", fiq_src, 7);
        chk("R12 fiq_prio", fiq_prio, 3);
        chk("R12 not on irq", irq_out, 0);
        src[7] = 1'b0; wr(0, 2, 32'h1); cyc(3);
        chk("R10 irq ack leaves fiq", fiq_out, 1);
        wr(0, 2, 32'h2); cyc(3);
        chk("R10 fiq ack", fiq_out, 0);

        // R11 cascade
        wr(0, 1, 32'hFFFF_FFFF);
        wr(1, 32 + 2, 4 << 2); wr(1, 1, ~(32'h1 << 2));
        src[34] = 1'b1; cyc(4);
        chk("R11 masked cascade", irq_out, 0);
        wr(0, 1, ~(32'h1 << CASC)); cyc(3);
        chk("R11 cascade irq", irq_out, 1);
        chk("R11 cascade src", irq_src, 34);
        chk("R11 cascade prio", irq_prio, 4);
        src[34] = 1'b0; wr(1, 2, 32'h1); cyc(3);
        chk("R11 second-level ack alone", irq_out, 1);
        wr(0, 2, 32'h1); cyc(3);
        chk("R11 both acked", irq_out, 0);

        // random trials: R2 R3 R5 R6 R11 R12
        for (int t = 0; t < 60; t++) begin
            src = '0;
            wr(1, 2, 32'h1); cyc(2); wr(0, 2, 32'h3); cyc(2);
            wr(1, 2, 32'h1); cyc(2); wr(0, 2, 32'h3); cyc(2);
            for (int b = 0; b < NB; b++) begin
                m_mask[b] = $urandom;
                wr(b, 1, m_mask[b]);
                for (int i = 0; i < 32; i++) begin
                    int p = $urandom % 4;
                    logic f = ($urandom % 4) == 0;
                    m_prio[b][i] = p;
                    m_fiq[b][i]  = (b == 0) ? f : 1'b0;
                    wr(b, 32 + i, {25'b0, p[4:0], 1'b0, f});
                end
            end
            for (int b = 1; b < NB; b++) src[b*32 +: 32] = $urandom & $urandom;
            cyc(4);
            src[31:0] = $urandom & $urandom;
            cyc(4);
            model(iv, is, ip, fv, fs, fp);
            chk("R3 rand irq_out", irq_out, iv);
            if (iv) begin
                chk("R6 rand irq_src", irq_src, is);
                chk("R11 rand irq_prio", irq_prio, ip);
            end
            chk("R12 rand fiq_out", fiq_out, fv);
            if (fv) begin
                chk("R5 rand fiq_src", fiq_src, fs);
                chk("R2 rand fiq_prio", fiq_prio, fp);
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule